// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block drives a raster display. It produces horizontal sync, vertical sync, a data-enable strobe and the current pixel column and line. All of these come from a set of 32-bit timing words. Each count in those words is written as the real value minus one. A mode word supplies a dot-clock ratio, a master display enable and a layer enable. The ratio sets how many core clocks each pixel lasts, and the block marks every pixel period with a one-cycle strobe.

The timing words and the mode fields, apart from the master enable, pass through a shadow stage. The shadow stage loads only on the clock edge where the last pixel of a frame wraps, or on any edge while the display is off. A mode change made during a frame therefore takes effect on the next frame and never splits one. The master enable acts at once. While it is clear, the counters sit at zero and every output stays low.

Top module: `raster_timing_gen`

## Requirements
- R1: With a ratio N in `mode_reg[11:8]`, `pix_stb` is high once every N+1 core clocks while the display runs. N=0 keeps it high on every clock.
- R2: `px_x` advances by one on each clock edge where `pix_stb` is high. After it reaches the horizontal total (`htot_reg[31:16]`, total minus one) it returns to 0. It holds on all other edges.
- R3: `px_y` advances by one on each edge where `px_x` wraps. After it reaches the vertical total (`vtot_reg[31:16]`) it returns to 0. A frame therefore lasts (htot+1)·(vtot+1)·(N+1) core clocks.
- R4: `de` is high exactly when `px_x` ≤ `hdisp_reg[15:0]` and `px_y` ≤ `vdisp_reg[31:16]`, with both enables set.
- R5: `hsync` is active high for `px_x` from `hsync_reg[15:0]` through `hsync_reg[15:0]` + `hsync_reg[23:16]`, both ends included.
- R6: `vsync` is active high for `px_y` from `vdisp_reg[15:0]` through `vdisp_reg[15:0]` + `hsync_reg[31:24]`, both ends included.
- R7: While `mode_reg[31]` is 0, `hsync`, `vsync`, `de` and `pix_stb` are low in the same cycle. From the next clock edge on, `px_x` and `px_y` are 0.
- R8: While `mode_reg[16]` (layer enable) is 0, `de` stays low and both syncs keep their normal timing.
- R9: A timing-word change made while the display runs takes effect only at the start of the next frame. A change made while the display is off takes effect at once.
- R10: While `rst_n` is low, `px_x` and `px_y` are 0. After reset with the display off, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| htot_reg | input | 32 | [31:16] horizontal total minus one |
| hdisp_reg | input | 32 | [15:0] last active column (width minus one) |
| hsync_reg | input | 32 | [31:24] vsync width−1, [23:16] hsync width−1, [15:0] hsync start |
| vtot_reg | input | 32 | [31:16] vertical total minus one |
| vdisp_reg | input | 32 | [31:16] last active line, [15:0] vsync start |
| mode_reg | input | 32 | [31] display enable, [16] layer enable, [11:8] dot-clock ratio |
| pix_stb | output | 1 | One-cycle pixel-period strobe |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable for the active area |
| px_x | output | CNT_W | Current column |
| px_y | output | CNT_W | Current line |

## Verification
`hsync`, `vsync` and `de` are combinational decodes of the counters, so each one is due in the same cycle as the column and line it belongs to. The counters move one edge after a sampled `pix_stb`. Dropping the master enable silences the outputs within that cycle and zeroes the counters at the following edge. The bench drives inputs just after a falling edge and samples one nanosecond later. Each step check compares the current sample with an expectation built from the previous sample's column, line and strobe. The shadow test measures the line length on both sides of the frame wrap that follows a mid-frame write.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

   localparam int FIELD_W        = 16;
   localparam int SW_W           = 8;
   localparam int DIV_W          = 4;
   localparam int MODE_EN_BIT    = 31;
   localparam int MODE_LAYER_BIT = 16;
   localparam int MODE_DIV_LSB   = 8;

   typedef struct packed {
      logic [FIELD_W-1:0] h_tot;
      logic [FIELD_W-1:0] h_end;
      logic [FIELD_W-1:0] h_ss;
      logic [SW_W-1:0]    h_sw;
      logic [FIELD_W-1:0] v_tot;
      logic [FIELD_W-1:0] v_end;
      logic [FIELD_W-1:0] v_ss;
      logic [SW_W-1:0]    v_sw;
      logic [DIV_W-1:0]   div;
      logic               layer;
   } rtg_cfg_t;

endpackage

// File: rtl/rtg_dot_div.sv
module rtg_dot_div #(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [DIV_W-1:0] ratio,
   output logic             stb
);

   logic [DIV_W-1:0] cnt_q;

   assign stb = (cnt_q == ratio);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr || stb) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/rtg_axis.sv
module rtg_axis #(
   parameter int CNT_W = 12,
   parameter int SW_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic [CNT_W-1:0] tot,
   input  logic [CNT_W-1:0] act_end,
   input  logic [CNT_W-1:0] sync_start,
   input  logic [SW_W-1:0]  sync_wid,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap,
   output logic             active,
   output logic             sync
);

   localparam int EXT_W = CNT_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic             at_end;
   logic [EXT_W-1:0] sync_last;

   assign at_end    = (cnt_q == tot);
   assign wrap      = step && at_end;
   assign cnt       = cnt_q;
   assign active    = (cnt_q <= act_end);
   assign sync_last = {1'b0, sync_start} + {{(EXT_W-SW_W){1'b0}}, sync_wid};
   assign sync      = (cnt_q >= sync_start) && ({1'b0, cnt_q} <= sync_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= at_end ? '0 : cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import rtg_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [31:0]      htot_reg,
   input  logic [31:0]      hdisp_reg,
   input  logic [31:0]      hsync_reg,
   input  logic [31:0]      vtot_reg,
   input  logic [31:0]      vdisp_reg,
   input  logic [31:0]      mode_reg,
   output logic             pix_stb,
   output logic             hsync,
   output logic             vsync,
   output logic             de,
   output logic [CNT_W-1:0] px_x,
   output logic [CNT_W-1:0] px_y
);

   generate
      if (CNT_W > FIELD_W || CNT_W < SW_W + 1) begin : g_bad_width
         $error("raster_timing_gen: CNT_W out of range");
      end
   endgenerate

   rtg_cfg_t         cfg_live;
   rtg_cfg_t         cfg_q;
   logic             disp_en;
   logic             layer_on;
   logic             frame_wrap;
   logic             div_stb;
   logic [DIV_W-1:0] div_q;
   logic [CNT_W-1:0] h_tot_q, h_de_q, h_ss_q;
   logic [CNT_W-1:0] v_tot_q, v_de_q, v_ss_q;
   logic             h_wrap, h_act, h_sync;
   logic             v_act, v_sync;
   logic             unused_reg_bits;

   assign disp_en = mode_reg[MODE_EN_BIT];

   assign cfg_live = '{
      h_tot: htot_reg[31:16],
      h_end: hdisp_reg[15:0],
      h_ss:  hsync_reg[15:0],
      h_sw:  hsync_reg[23:16],
      v_tot: vtot_reg[31:16],
      v_end: vdisp_reg[31:16],
      v_ss:  vdisp_reg[15:0],
      v_sw:  hsync_reg[31:24],
      div:   mode_reg[MODE_DIV_LSB +: DIV_W],
      layer: mode_reg[MODE_LAYER_BIT]
   };

   assign unused_reg_bits = ^{htot_reg[15:0], hdisp_reg[31:16], vtot_reg[15:0],
                              mode_reg[30:17], mode_reg[15:12], mode_reg[7:0]};

   // Shadow stage: follows the live words while idle, otherwise only at frame wrap
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (!disp_en || frame_wrap) begin
         cfg_q <= cfg_live;
      end
   end

   assign h_tot_q  = cfg_q.h_tot[CNT_W-1:0];
   assign h_de_q   = cfg_q.h_end[CNT_W-1:0];
   assign h_ss_q   = cfg_q.h_ss[CNT_W-1:0];
   assign v_tot_q  = cfg_q.v_tot[CNT_W-1:0];
   assign v_de_q   = cfg_q.v_end[CNT_W-1:0];
   assign v_ss_q   = cfg_q.v_ss[CNT_W-1:0];
   assign div_q    = cfg_q.div;
   assign layer_on = cfg_q.layer;

   generate
      if (CNT_W < FIELD_W) begin : g_trim
         logic unused_hi_bits;
         assign unused_hi_bits = ^{cfg_q.h_tot[FIELD_W-1:CNT_W], cfg_q.h_end[FIELD_W-1:CNT_W],
                                   cfg_q.h_ss[FIELD_W-1:CNT_W],  cfg_q.v_tot[FIELD_W-1:CNT_W],
                                   cfg_q.v_end[FIELD_W-1:CNT_W], cfg_q.v_ss[FIELD_W-1:CNT_W]};
      end
   endgenerate

   rtg_dot_div #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!disp_en),
      .ratio (div_q),
      .stb   (div_stb)
   );

   assign pix_stb = disp_en && div_stb;

   rtg_axis #(.CNT_W(CNT_W), .SW_W(SW_W)) u_h (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (!disp_en),
      .step       (pix_stb),
      .tot        (h_tot_q),
      .act_end    (h_de_q),
      .sync_start (h_ss_q),
      .sync_wid   (cfg_q.h_sw),
      .cnt        (px_x),
      .wrap       (h_wrap),
      .active     (h_act),
      .sync       (h_sync)
   );

   rtg_axis #(.CNT_W(CNT_W), .SW_W(SW_W)) u_v (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (!disp_en),
      .step       (h_wrap),
      .tot        (v_tot_q),
      .act_end    (v_de_q),
      .sync_start (v_ss_q),
      .sync_wid   (cfg_q.v_sw),
      .cnt        (px_y),
      .wrap       (frame_wrap),
      .active     (v_act),
      .sync       (v_sync)
   );

   assign hsync = disp_en && h_sync;
   assign vsync = disp_en && v_sync;
   assign de    = disp_en && layer_on && h_act && v_act;

endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
   parameter int CNT_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             disp_en,
   input logic             layer_on,
   input logic             pix_stb,
   input logic             hsync,
   input logic             vsync,
   input logic             de,
   input logic [CNT_W-1:0] px_x,
   input logic [CNT_W-1:0] px_y,
   input logic [CNT_W-1:0] h_tot_q,
   input logic [CNT_W-1:0] h_de_q,
   input logic [CNT_W-1:0] v_de_q,
   input logic [3:0]       div_q
);

   // R7
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_en |=> (px_x == '0 && px_y == '0));

   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_en |-> !(hsync || vsync || de || pix_stb));

   // R1
   stb_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_stb && div_q != 4'd0) |=> !pix_stb);

   // R2
   x_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_en && !pix_stb) |=> $stable(px_x));

   // R2
   x_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_en && pix_stb && px_x == h_tot_q) |=> (px_x == '0));

   // R3
   y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_en && !(pix_stb && px_x == h_tot_q)) |=> $stable(px_y));

   // R4
   de_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> (px_x <= h_de_q && px_y <= v_de_q));

   // R8
   layer_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !layer_on |-> !de);

endmodule

bind raster_timing_gen rtg_checker #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .disp_en  (disp_en),
   .layer_on (layer_on),
   .pix_stb  (pix_stb),
   .hsync    (hsync),
   .vsync    (vsync),
   .de       (de),
   .px_x     (px_x),
   .px_y     (px_y),
   .h_tot_q  (h_tot_q),
   .h_de_q   (h_de_q),
   .v_de_q   (v_de_q),
   .div_q    (div_q)
);

// File: tb/raster_timing_gen_bench.sv
`timescale 1ns/1ps
module raster_timing_gen_bench;

   localparam int CW = 12;
   // Test mode: 8 columns (4 active), hsync at 4..5; 6 lines (3 active), vsync at 3..4
   localparam int HTOT = 7, HEND = 3, HSS = 4, HSW = 1;
   localparam int VTOT = 5, VEND = 2, VSS = 3, VSW = 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [31:0]   htot_reg, hdisp_reg, hsync_reg, vtot_reg, vdisp_reg, mode_reg;
   logic          pix_stb, hsync, vsync, de;
   logic [CW-1:0] px_x, px_y;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   raster_timing_gen #(.CNT_W(CW)) u_raster_timing_gen (
      .clk (clk), .rst_n (rst_n),
      .htot_reg (htot_reg), .hdisp_reg (hdisp_reg), .hsync_reg (hsync_reg),
      .vtot_reg (vtot_reg), .vdisp_reg (vdisp_reg), .mode_reg (mode_reg),
      .pix_stb (pix_stb), .hsync (hsync), .vsync (vsync), .de (de),
      .px_x (px_x), .px_y (px_y)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic set_mode(input bit en, input bit layer, input int div);
      mode_reg = {en, 14'b0, layer, 4'b0, div[3:0], 8'b0};
   endtask

   task automatic load_words(input int htot);
      htot_reg  = {htot[15:0], 16'd0};
      hdisp_reg = {16'd0, 16'(HEND)};
      hsync_reg = {8'(VSW), 8'(HSW), 16'(HSS)};
      vtot_reg  = {16'(VTOT), 16'd0};
      vdisp_reg = {16'(VEND), 16'(VSS)};
   endtask

   task automatic restart(input int div, input bit layer);
      set_mode(1'b0, layer, div);
      tick();
      tick();
      set_mode(1'b1, layer, div);
      #1;
   endtask

   task automatic t_reset();
      load_words(HTOT);
      set_mode(1'b1, 1'b1, 0);
      tick();
      tick();
      chk("R10 x held in reset", int'(px_x), 0);
      chk("R10 y held in reset", int'(px_y), 0);
      set_mode(1'b0, 1'b1, 0);
      rst_n = 1'b1;
      tick();
      chk("R10 outputs after reset", int'({pix_stb, hsync, vsync, de}), 0);
      chk("R10 x after reset", int'(px_x), 0);
      chk("R10 y after reset", int'(px_y), 0);
   endtask

   task automatic t_divider(input int n);
      int first = -1, prev = -1, seen = 0;
      restart(n, 1'b1);
      for (int i = 0; i < 120 && seen < 5; i++) begin
         if (pix_stb) begin
            if (prev >= 0) chk($sformatf("R1 strobe gap N=%0d", n), i - prev, n + 1);
            if (first < 0) first = i;
            prev = i;
            seen++;
         end
         tick();
      end
      chk($sformatf("R1 strobes seen N=%0d", n), seen, 5);
   endtask

   task automatic t_raster(input int div, input int n);
      int x, y, px = 0, py = 0;
      bit ps = 1'b0;
      restart(div, 1'b1);
      for (int i = 0; i < n; i++) begin
         x = int'(px_x);
         y = int'(px_y);
         if (i > 0) begin
            chk("R2 column step", x, ps ? ((px == HTOT) ? 0 : px + 1) : px);
            chk("R3 line step", y, (ps && px == HTOT) ? ((py == VTOT) ? 0 : py + 1) : py);
         end
         chk("R5 hsync window", int'(hsync), int'(x >= HSS && x <= HSS + HSW));
         chk("R6 vsync window", int'(vsync), int'(y >= VSS && y <= VSS + VSW));
         chk("R4 active area", int'(de), int'(x <= HEND && y <= VEND));
         px = x;
         py = y;
         ps = pix_stb;
         tick();
      end
   endtask

   task automatic t_frame();
      int r1 = -1, r2 = -1;
      bit pv = 1'b0;
      restart(1, 1'b1);
      for (int i = 0; i < 400; i++) begin
         if (vsync && !pv) begin
            if (r1 < 0) r1 = i;
            else if (r2 < 0) r2 = i;
         end
         pv = vsync;
         tick();
      end
      chk("R3 frame length in clocks", r2 - r1, (HTOT + 1) * (VTOT + 1) * 2);
   endtask

   task automatic t_layer_off();
      int nde = 0, nhs = 0, nvs = 0;
      restart(0, 1'b0);
      for (int i = 0; i < (HTOT + 1) * (VTOT + 1); i++) begin
         nde += int'(de);
         nhs += int'(hsync);
         nvs += int'(vsync);
         tick();
      end
      chk("R8 de with layer off", nde, 0);
      chk("R8 hsync count with layer off", nhs, (HSW + 1) * (VTOT + 1));
      chk("R8 vsync count with layer off", nvs, (VSW + 1) * (HTOT + 1));
   endtask

   task automatic t_disable();
      restart(0, 1'b1);
      for (int i = 0; i < 60 && !hsync; i++) tick();
      chk("R7 hsync seen before disable", int'(hsync), 1);
      set_mode(1'b0, 1'b1, 0);
      #1;
      chk("R7 outputs low at once", int'({pix_stb, hsync, vsync, de}), 0);
      for (int i = 0; i < 4; i++) begin
         tick();
         chk("R7 x zero while off", int'(px_x), 0);
         chk("R7 y zero while off", int'(px_y), 0);
         chk("R7 outputs low while off", int'({pix_stb, hsync, vsync, de}), 0);
      end
   endtask

   task automatic t_shadow();
      int maxx = 0;
      load_words(HTOT);
      restart(0, 1'b1);
      for (int i = 0; i < 100 && px_y != 1; i++) tick();
      load_words(9);
      for (int i = 0; i < 200 && px_y != 0; i++) begin
         if (int'(px_x) > maxx) maxx = int'(px_x);
         tick();
      end
      chk("R9 old line length kept to frame end", maxx, HTOT);
      chk("R9 new frame starts at column 0", int'(px_x), 0);
      maxx = 0;
      for (int i = 0; i < 10 * (VTOT + 1); i++) begin
         if (int'(px_x) > maxx) maxx = int'(px_x);
         tick();
      end
      chk("R9 new line length after frame wrap", maxx, 9);
      chk("R9 frame of new length ends at column 0", int'(px_x), 0);
      chk("R9 frame of new length ends at line 0", int'(px_y), 0);
      load_words(HTOT);
      restart(0, 1'b1);
      for (int i = 0; i < 10; i++) tick();
      chk("R9 change while off applies at once", int'(px_x), 2);
   endtask

   initial begin
      #(200000 * 5);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_divider(0);
      t_divider(2);
      t_divider(5);
      t_raster(0, 2 * (HTOT + 1) * (VTOT + 1));
      t_raster(2, 2 * 3 * (HTOT + 1) * (VTOT + 1));
      t_frame();
      t_layer_off();
      t_disable();
      t_shadow();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule